// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block derives the four switching phases of a switched-capacitor converter pipeline from a single fast reference clock. A synchronous counter walks through one conversion period of two half periods. Two main phases, `ph1_o` and `ph2_o`, take turns, one per half period, and a dead gap separates them. During that gap neither phase is high, so a sampling switch and a transfer switch can never conduct at the same time. Each main phase also has an early partner that rises with it but opens a programmable lag sooner. Switches driven by the early partner therefore disconnect before the main switch does, which keeps charge injection off the hold capacitors.

Odd pipeline stages sample on `ph1_o` and drive their residue on `ph2_o`. Even stages swap the two. The half period, the gap and the lag are integer counts of reference ticks, so every edge falls on a reference edge. Every output is taken straight from a flip-flop and cannot glitch. A setting that leaves no room for both gaps plus the lag inside a half period is refused, and all four outputs then stay low.

Top module: `nov_clkgen`

## Requirements
- R1: `ph1_o` and `ph2_o` are never high in the same reference cycle.
- R2: After either main phase falls, the other main phase rises exactly `gap_i` reference ticks later.
- R3: Each main phase stays high for `half_period_i - gap_i` ticks, and it repeats every `2*half_period_i` ticks.
- R4: Each early phase rises in the same tick as its main phase and falls `lag_i` ticks before that main phase falls (the same tick when `lag_i` is 0). It is never high while its main phase is low.
- R5: While `rst_ni` is low, all four outputs are low. Counting the first reference edge after release as edge 1, `ph1_o` and `ph1_early_o` first go high on edge number `gap_i`.
- R6: A setting is accepted only when `gap_i >= 1` and `2*gap_i + lag_i < half_period_i`. Otherwise all four outputs are low from the next tick on. When an accepted setting returns, the sequence restarts as it does after reset.
- R7: `ph2_o` and `ph2_early_o` follow the same shape as `ph1_o` and `ph1_early_o`, shifted by exactly `half_period_i` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all timing is in its ticks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_period_i | input | CNT_W | Half conversion period in ticks |
| gap_i | input | CNT_W | Non-overlap gap in ticks |
| lag_i | input | CNT_W | Early-release lead in ticks |
| ph1_o | output | 1 | Main phase one |
| ph2_o | output | 1 | Main phase two |
| ph1_early_o | output | 1 | Early-release partner of phase one |
| ph2_early_o | output | 1 | Early-release partner of phase two |

## Verification
The outputs are a pure function of the period counter, so an off-by-one or a bad wrap in that counter moves an edge. A behavioural model sees that shift at the ports within one conversion period. Gap, high time and lag are also measured from the observed edges and compared with the configured counts, so a decode window that opens or closes one tick wrong shows up at the first edge it affects. Runs with refused settings, and with a refused setting followed by an accepted one, show whether the validity gate holds the outputs low and whether the restart lands ph1 on the gap-th edge.

// File: rtl/nov_pkg.sv
package nov_pkg;
  localparam int unsigned NUM_PH = 2;

  typedef enum logic {
    PH_ONE = 1'b0,
    PH_TWO = 1'b1
  } phase_e;
endpackage

// File: rtl/nov_cfg_check.sv
module nov_cfg_check #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] half_period_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] lag_i,
  output logic             valid_o
);
  localparam int unsigned SW = CNT_W + 2;

  logic [SW-1:0] need;

  // two gaps plus the lag must fit strictly inside a half period
  assign need    = ({2'b00, gap_i} << 1) + {2'b00, lag_i};
  assign valid_o = (gap_i != '0) && (need < {2'b00, half_period_i});
endmodule

// File: rtl/nov_phase_cnt.sv
module nov_phase_cnt #(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned CW   = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] half_period_i,
  output logic [CW-1:0]    cnt_nxt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] period;

  assign period  = {half_period_i, 1'b0};
  assign cnt_inc = cnt_q + CW'(1);

  always_comb begin
    if (!valid_i)                cnt_nxt_o = '0;
    else if (cnt_inc >= period)  cnt_nxt_o = '0;
    else                         cnt_nxt_o = cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/nov_phase_dec.sv
module nov_phase_dec #(
  parameter int unsigned      CNT_W  = 8,
  parameter nov_pkg::phase_e  PH_SEL = nov_pkg::PH_ONE,
  localparam int unsigned     CW     = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [CNT_W-1:0] half_period_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] lag_i,
  output logic             main_o,
  output logic             early_o
);
  logic [CW-1:0] start, open_at, close_at, early_close;
  logic          main_d, early_d;

  assign start       = (PH_SEL == nov_pkg::PH_TWO) ? {1'b0, half_period_i} : '0;
  assign open_at     = start + {1'b0, gap_i};
  assign close_at    = start + {1'b0, half_period_i};
  assign early_close = close_at - {1'b0, lag_i};

  assign main_d  = valid_i && (cnt_i >= open_at) && (cnt_i < close_at);
  assign early_d = valid_i && (cnt_i >= open_at) && (cnt_i < early_close);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_o  <= 1'b0;
      early_o <= 1'b0;
    end else begin
      main_o  <= main_d;
      early_o <= early_d;
    end
  end

  AST_EARLY_WITHIN_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> main_o); // R4
endmodule

// File: rtl/nov_clkgen.sv
module nov_clkgen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] half_period_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] lag_i,
  output logic             ph1_o,
  output logic             ph2_o,
  output logic             ph1_early_o,
  output logic             ph2_early_o
);
  localparam int unsigned CW = CNT_W + 1;

  logic                       cfg_ok;
  logic [CW-1:0]              cnt_nxt;
  logic [nov_pkg::NUM_PH-1:0] main_v, early_v;

  nov_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .half_period_i(half_period_i),
    .gap_i        (gap_i),
    .lag_i        (lag_i),
    .valid_o      (cfg_ok)
  );

  nov_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (cfg_ok),
    .half_period_i(half_period_i),
    .cnt_nxt_o    (cnt_nxt)
  );

  for (genvar i = 0; i < nov_pkg::NUM_PH; i++) begin : g_ph
    nov_phase_dec #(
      .CNT_W (CNT_W),
      .PH_SEL(nov_pkg::phase_e'(i))
    ) u_dec (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .valid_i      (cfg_ok),
      .cnt_i        (cnt_nxt),
      .half_period_i(half_period_i),
      .gap_i        (gap_i),
      .lag_i        (lag_i),
      .main_o       (main_v[i]),
      .early_o      (early_v[i])
    );
  end

  assign ph1_o       = main_v[0];
  assign ph2_o       = main_v[1];
  assign ph1_early_o = early_v[0];
  assign ph2_early_o = early_v[1];

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph1_o && ph2_o)); // R1

  AST_GAP_AFTER_PH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph1_o) |-> !ph2_o); // R2

  AST_GAP_AFTER_PH2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph2_o) |-> !ph1_o); // R2

  AST_EARLY_RISES_WITH_PH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph1_o) |-> $rose(ph1_early_o)); // R4

  AST_EARLY_RISES_WITH_PH2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph2_o) |-> $rose(ph2_early_o)); // R7

  AST_REFUSED_CFG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok |=> !(ph1_o || ph2_o || ph1_early_o || ph2_early_o)); // R6
endmodule

// File: tb/nov_clkgen_tb_top.sv
module nov_clkgen_tb_top;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] half_p = 8'd5, gap = 8'd1, lag = 8'd1;
  logic             ph1, ph2, ph1e, ph2e;

  int checks = 0, errors = 0;
  int cyc = 0;
  int k = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nov_clkgen #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .half_period_i(half_p), .gap_i(gap), .lag_i(lag),
    .ph1_o(ph1), .ph2_o(ph2), .ph1_early_o(ph1e), .ph2_early_o(ph2e)
  );

  function automatic bit cfg_ok();
    return (int'(gap) >= 1) && (2*int'(gap) + int'(lag) < int'(half_p));
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: tick count since the last restart
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || !cfg_ok()) k <= 0;
    else                      k <= k + 1;
  end

  // edge measurements, index 0 = phase one, 1 = phase two
  int  rise_t [2], fall_t [2], efall_t [2];
  bit  have_rise [2], have_fall [2], have_ef [2];
  bit  prev_m [2], prev_e [2];

  task automatic clear_meas();
    for (int i = 0; i < 2; i++) begin
      have_rise[i] = 0; have_fall[i] = 0; have_ef[i] = 0;
    end
  endtask

  always @(negedge clk) begin
    bit em [2], ee [2], am [2], ae [2];
    int p, h, g, l;
    h = int'(half_p); g = int'(gap); l = int'(lag);
    am[0] = ph1; am[1] = ph2; ae[0] = ph1e; ae[1] = ph2e;
    if (!rst_n) begin
      check({ph1, ph2, ph1e, ph2e} == 4'b0, "R5", int'({ph1, ph2, ph1e, ph2e}), 0);
      clear_meas();
    end else if (!cfg_ok()) begin
      check({ph1, ph2, ph1e, ph2e} == 4'b0, "R6", int'({ph1, ph2, ph1e, ph2e}), 0);
      clear_meas();
    end else begin
      p = k % (2*h);
      for (int i = 0; i < 2; i++) begin
        int s;
        s = i * h;
        em[i] = (p >= s + g) && (p < s + h);
        ee[i] = (p >= s + g) && (p < s + h - l);
      end
      check(am[0] == em[0], "R5 ph1 model", am[0], em[0]);
      check(ae[0] == ee[0], "R4 ph1_early model", ae[0], ee[0]);
      check(am[1] == em[1], "R7 ph2 model", am[1], em[1]);
      check(ae[1] == ee[1], "R7 ph2_early model", ae[1], ee[1]);
      check(!(ph1 && ph2), "R1 overlap", int'({ph1, ph2}), 0);
      for (int i = 0; i < 2; i++) begin
        if (ae[i] && !am[i]) check(0, "R4 early outside main", 1, 0);
        if (am[i] && !prev_m[i]) begin
          check(ae[i], "R4 early rise with main", ae[i], 1);
          if (have_fall[1-i]) check(cyc - fall_t[1-i] == g, "R2 gap", cyc - fall_t[1-i], g);
          if (have_rise[i]) check(cyc - rise_t[i] == 2*h, "R3 period", cyc - rise_t[i], 2*h);
          rise_t[i] = cyc; have_rise[i] = 1;
        end
        if (!ae[i] && prev_e[i]) begin efall_t[i] = cyc; have_ef[i] = 1; end
        if (!am[i] && prev_m[i]) begin
          if (have_rise[i]) check(cyc - rise_t[i] == h - g, "R3 high time", cyc - rise_t[i], h - g);
          if (have_ef[i]) check(cyc - efall_t[i] == l, "R4 lag", cyc - efall_t[i], l);
          fall_t[i] = cyc; have_fall[i] = 1;
        end
      end
    end
    prev_m[0] = ph1; prev_m[1] = ph2; prev_e[0] = ph1e; prev_e[1] = ph2e;
  end

  // reset with a new setting, then count edges to first ph1 rise
  task automatic run_cfg(input int h, input int g, input int l, input int n);
    int first;
    @(negedge clk); #2;
    rst_n = 0; half_p = CNT_W'(h); gap = CNT_W'(g); lag = CNT_W'(l);
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    first = -1;
    for (int e = 1; e <= n; e++) begin
      @(negedge clk);
      if (first < 0 && ph1) first = e;
    end
    if (cfg_ok()) begin
      check(first == g, "R5 first ph1 edge", first, g);
    end else begin
      check(first == -1, "R6 refused setting stays low", first, -1);
    end
  endtask

  initial begin
    clear_meas();
    prev_m = '{0, 0}; prev_e = '{0, 0};
    run_cfg(5, 1, 1, 60);
    run_cfg(10, 2, 3, 120);
    run_cfg(20, 4, 0, 200);
    run_cfg(4, 1, 1, 50);
    run_cfg(5, 2, 1, 40);   // 2*2+1 == 5: refused
    run_cfg(8, 0, 2, 40);   // zero gap: refused
    run_cfg(255, 60, 100, 1100);
    // refuse mid-run, then restore: restart like reset
    run_cfg(6, 1, 2, 30);
    @(negedge clk); #2 lag = 8'd5;
    repeat (10) @(negedge clk);
    check(!(ph1 || ph2 || ph1e || ph2e), "R6 refused mid-run", int'({ph1, ph2, ph1e, ph2e}), 0);
    @(negedge clk); #2 lag = 8'd2;
    begin
      int first;
      first = -1;
      for (int e = 1; e <= 20; e++) begin
        @(negedge clk);
        if (first < 0 && ph1) first = e;
      end
      check(first == 1, "R6 restart after restore", first, 1);
    end
    repeat (40) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule